// File: doc/BRIEF.md
# Single-Port Memory Fetch Stall Controller

This block is the control slice of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) in which instruction fetch and data loads/stores go through one memory port. Each cycle it checks whether the instruction now in the memory stage needs the port. A valid load or store there takes the port. If fetch also wanted the port in that cycle, the fetch is held off for one cycle.

During that cycle the block freezes the program counter and the fetch/decode register, and it pushes an empty slot into decode. Instructions already past fetch keep moving. Only the fetch that lost the port is delayed, and every later fetch moves back by one cycle. The block also drives the shared port. It forwards the memory-stage address and write enable when data wins, and the PC otherwise.

The block has one register: a valid bit for the fetch/decode slot. Reset clears it, and it shows decode whether a real instruction arrived.

Top module: `shared_port_stall_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ifid_valid_o` is 0, whatever `fetch_req_i` does.
- R2: When `mem_valid_i` is 1 and `mem_load_i` or `mem_store_i` is 1, the data side owns the port. In that case `port_data_sel_o` is 1, `port_addr_o` equals `mem_addr_i`, and `port_we_o` equals `mem_store_i`.
- R3: When `mem_valid_i` is 0, the load/store flags are ignored. `port_data_sel_o` is 0, `port_addr_o` equals `pc_i`, `port_we_o` is 0, and no stall is raised.
- R4: `pc_hold_o`, `ifid_hold_o` and `bubble_o` are each 1 exactly when the data side owns the port and `fetch_req_i` is 1. Otherwise all three are 0. All three are combinational in the same cycle.
- R5: One clock edge later, `ifid_valid_o` is 1 exactly when `fetch_req_i` was 1 and the data side did not own the port. A stalled cycle therefore puts an empty slot into decode.
- R6: In a closed-loop pipeline where instruction k is fetched in cycle c and reaches the memory stage in cycle c+3, suppose a load is fetched in cycle 1. Then the third instruction after it is fetched in cycle 5 rather than 4, and each later fetch is one cycle later.
- R7: A run of consecutive memory instructions costs one stall cycle per data reference, and stores stall fetch just as loads do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_valid_i | input | 1 | Memory-stage slot holds a real instruction |
| mem_load_i | input | 1 | Memory-stage instruction reads data |
| mem_store_i | input | 1 | Memory-stage instruction writes data |
| mem_addr_i | input | AW | Data address from the memory stage |
| fetch_req_i | input | 1 | Fetch wants the port this cycle |
| pc_i | input | AW | Fetch address |
| port_data_sel_o | output | 1 | 1: port serves data, 0: port serves fetch |
| port_addr_o | output | AW | Address presented to the shared memory |
| port_we_o | output | 1 | Write enable presented to the shared memory |
| pc_hold_o | output | 1 | Freeze the program counter |
| ifid_hold_o | output | 1 | Freeze the fetch/decode register contents |
| bubble_o | output | 1 | Insert an empty slot into decode |
| ifid_valid_o | output | 1 | Fetch/decode slot holds a real instruction |

## Verification
All sixteen combinations of memory-stage valid, load, store and fetch request are swept. Each has its own address pattern, so a mux that picks the wrong source shows up as a wrong address value. The sweep separates ownership by a valid slot from flags on an empty slot, loads from stores on the write enable, and a stall from a simple lack of fetch demand. The bench then closes the loop with its own three-stage model that feeds the memory-stage inputs back from earlier grants. It runs a lone load, a back-to-back burst and a mixed store/load program, and compares every fetch cycle with a schedule computed arithmetically. This catches extra stalls, missing stalls and stalls placed in the wrong cycle.

// File: rtl/spsc_pkg.sv
package spsc_pkg;

    typedef enum logic {
        SRC_FETCH = 1'b0,
        SRC_DATA  = 1'b1
    } port_src_e;

    typedef struct packed {
        logic ifid_valid;
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '{ifid_valid: 1'b0};

endpackage

// File: rtl/spsc_claim_dec.sv
module spsc_claim_dec (
    input  logic                   valid_i,
    input  logic                   load_i,
    input  logic                   store_i,
    output spsc_pkg::port_src_e    src_o,
    output logic                   write_o
);
    import spsc_pkg::*;

    logic wants_mem;

    always_comb begin
        wants_mem = valid_i && (load_i || store_i);
        src_o     = wants_mem ? SRC_DATA : SRC_FETCH;
        write_o   = wants_mem && store_i;
    end
endmodule

// File: rtl/spsc_port_mux.sv
module spsc_port_mux #(
    parameter int AW = 16
) (
    input  spsc_pkg::port_src_e src_i,
    input  logic [AW-1:0]       data_addr_i,
    input  logic                data_we_i,
    input  logic [AW-1:0]       fetch_addr_i,
    output logic [AW-1:0]       addr_o,
    output logic                we_o
);
    import spsc_pkg::*;

    always_comb begin
        if (src_i == SRC_DATA) begin
            addr_o = data_addr_i;
            we_o   = data_we_i;
        end else begin
            addr_o = fetch_addr_i;
            we_o   = 1'b0;
        end
    end
endmodule

// File: rtl/spsc_fetch_gate.sv
module spsc_fetch_gate (
    input  spsc_pkg::port_src_e src_i,
    input  logic                fetch_req_i,
    output logic                stall_o,
    output logic                fetch_go_o
);
    import spsc_pkg::*;

    always_comb begin
        stall_o    = (src_i == SRC_DATA) && fetch_req_i;
        fetch_go_o = (src_i == SRC_FETCH) && fetch_req_i;
    end
endmodule

// File: rtl/shared_port_stall_ctrl.sv
module shared_port_stall_ctrl #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_valid_i,
    input  logic          mem_load_i,
    input  logic          mem_store_i,
    input  logic [AW-1:0] mem_addr_i,
    input  logic          fetch_req_i,
    input  logic [AW-1:0] pc_i,
    output logic          port_data_sel_o,
    output logic [AW-1:0] port_addr_o,
    output logic          port_we_o,
    output logic          pc_hold_o,
    output logic          ifid_hold_o,
    output logic          bubble_o,
    output logic          ifid_valid_o
);
    import spsc_pkg::*;

    port_src_e   src;
    logic        data_we;
    logic        stall;
    logic        fetch_go;
    ctrl_state_t st_d;
    ctrl_state_t st_q;

    // Ownership of the port for this cycle
    spsc_claim_dec u_claim (
        .valid_i (mem_valid_i),
        .load_i  (mem_load_i),
        .store_i (mem_store_i),
        .src_o   (src),
        .write_o (data_we)
    );

    // Address and write-enable steering
    spsc_port_mux #(.AW(AW)) u_mux (
        .src_i        (src),
        .data_addr_i  (mem_addr_i),
        .data_we_i    (data_we),
        .fetch_addr_i (pc_i),
        .addr_o       (port_addr_o),
        .we_o         (port_we_o)
    );

    // Fetch stall decision
    spsc_fetch_gate u_gate (
        .src_i       (src),
        .fetch_req_i (fetch_req_i),
        .stall_o     (stall),
        .fetch_go_o  (fetch_go)
    );

    always_comb begin
        st_d            = st_q;
        st_d.ifid_valid = fetch_go;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CTRL_RESET;
        else        st_q <= st_d;
    end

    assign port_data_sel_o = (src == SRC_DATA);
    assign pc_hold_o       = stall;
    assign ifid_hold_o     = stall;
    assign bubble_o        = stall;
    assign ifid_valid_o    = st_q.ifid_valid;
endmodule

// File: rtl/shared_port_stall_ctrl_chk.sv
module shared_port_stall_ctrl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_valid_i,
    input logic          mem_store_i,
    input logic [AW-1:0] mem_addr_i,
    input logic          fetch_req_i,
    input logic [AW-1:0] pc_i,
    input logic          port_data_sel_o,
    input logic [AW-1:0] port_addr_o,
    input logic          port_we_o,
    input logic          pc_hold_o,
    input logic          ifid_hold_o,
    input logic          bubble_o,
    input logic          ifid_valid_o
);
    // R1: no valid decode slot in the first cycle out of reset
    a_r1_reset_empty: assert property (@(posedge clk) !rst_n |=> !ifid_valid_o);

    // R2: the data address is on the port whenever data owns it
    a_r2_data_addr: assert property (@(posedge clk) disable iff (!rst_n)
        port_data_sel_o |-> (port_addr_o == mem_addr_i));

    // R2: a write happens only for a store that owns the port
    a_r2_we_store: assert property (@(posedge clk) disable iff (!rst_n)
        port_we_o |-> (port_data_sel_o && mem_store_i));

    // R3: an empty memory-stage slot never raises a stall
    a_r3_empty_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid_i |-> (!bubble_o && !pc_hold_o && port_addr_o == pc_i));

    // R4: the three stall outputs move together
    a_r4_hold_together: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |-> (pc_hold_o && ifid_hold_o && fetch_req_i));

    // R5: a stalled cycle leaves an empty decode slot
    a_r5_bubble_empty: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |=> !ifid_valid_o);

    // R5: a served fetch fills the decode slot
    a_r5_fetch_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_i && !port_data_sel_o) |=> ifid_valid_o);
endmodule

bind shared_port_stall_ctrl shared_port_stall_ctrl_chk #(.AW(AW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mem_valid_i     (mem_valid_i),
    .mem_store_i     (mem_store_i),
    .mem_addr_i      (mem_addr_i),
    .fetch_req_i     (fetch_req_i),
    .pc_i            (pc_i),
    .port_data_sel_o (port_data_sel_o),
    .port_addr_o     (port_addr_o),
    .port_we_o       (port_we_o),
    .pc_hold_o       (pc_hold_o),
    .ifid_hold_o     (ifid_hold_o),
    .bubble_o        (bubble_o),
    .ifid_valid_o    (ifid_valid_o)
);

// File: tb/tb_shared_port_stall_ctrl.sv
`timescale 1ns/1ps
module tb_shared_port_stall_ctrl;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mem_valid_i, mem_load_i, mem_store_i, fetch_req_i;
    logic [AW-1:0] mem_addr_i, pc_i;
    logic          port_data_sel_o, port_we_o, pc_hold_o, ifid_hold_o, bubble_o, ifid_valid_o;
    logic [AW-1:0] port_addr_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    shared_port_stall_ctrl #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .mem_valid_i(mem_valid_i), .mem_load_i(mem_load_i), .mem_store_i(mem_store_i),
        .mem_addr_i(mem_addr_i), .fetch_req_i(fetch_req_i), .pc_i(pc_i),
        .port_data_sel_o(port_data_sel_o), .port_addr_o(port_addr_o), .port_we_o(port_we_o),
        .pc_hold_o(pc_hold_o), .ifid_hold_o(ifid_hold_o), .bubble_o(bubble_o),
        .ifid_valid_o(ifid_valid_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Closed-loop run: memory-stage inputs come from the bench's own pipe model
    task automatic run_prog(input logic [7:0] ops, input logic [7:0] sto, input int n, input string req);
        int exp_c [8];
        int got_c [8];
        int s_id, s_ex, s_mem, nxt, cyc;
        bit hit, got;
        for (int k = 0; k < 8; k++) begin exp_c[k] = -1; got_c[k] = -1; end
        for (int k = 0; k < n; k++) begin
            exp_c[k] = (k == 0) ? 1 : exp_c[k-1] + 1;
            hit = 1'b1;
            while (hit) begin
                hit = 1'b0;
                for (int j = 0; j < k; j++)
                    if (ops[j] && exp_c[j] + 3 == exp_c[k]) hit = 1'b1;
                if (hit) exp_c[k]++;
            end
        end
        s_id = -1; s_ex = -1; s_mem = -1; nxt = 0; cyc = 1;
        for (int step = 0; step < 30; step++) begin
            @(negedge clk);
            mem_valid_i = (s_mem >= 0);
            mem_load_i  = (s_mem >= 0) ? (ops[s_mem] && !sto[s_mem]) : 1'b1;
            mem_store_i = (s_mem >= 0) ? (ops[s_mem] && sto[s_mem]) : 1'b0;
            mem_addr_i  = 16'hD000 + AW'(step);
            fetch_req_i = (nxt < n);
            pc_i        = AW'(nxt);
            #1;
            got = fetch_req_i && !pc_hold_o;
            if (got) got_c[nxt] = cyc;
            @(posedge clk);
            s_mem = s_ex; s_ex = s_id; s_id = got ? nxt : -1;
            if (got) nxt++;
            cyc++;
        end
        for (int k = 0; k < n; k++)
            check(got_c[k] == exp_c[k], req, got_c[k], exp_c[k]);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        mem_valid_i = 1'b0; mem_load_i = 1'b0; mem_store_i = 1'b0;
        mem_addr_i = '0; pc_i = '0; fetch_req_i = 1'b1;
        repeat (3) @(negedge clk);
        #1 check(ifid_valid_o == 1'b0, "R1 reset", ifid_valid_o, 0);
        @(negedge clk); rst_n = 1'b1;
        #1 check(ifid_valid_o == 1'b0, "R1 first cycle", ifid_valid_o, 0);

        // Sweep all flag combinations
        for (int c = 0; c < 16; c++) begin
            bit v, ld, st, fr, own;
            @(negedge clk);
            v = c[0]; ld = c[1]; st = c[2]; fr = c[3];
            mem_valid_i = v; mem_load_i = ld; mem_store_i = st; fetch_req_i = fr;
            mem_addr_i = 16'hA000 + AW'(c);
            pc_i       = 16'h0100 + AW'(c);
            own = v && (ld || st);
            #1;
            if (v) check(port_data_sel_o == own, "R2 select", port_data_sel_o, own);
            else   check(port_data_sel_o == 1'b0, "R3 select", port_data_sel_o, 0);
            check(port_addr_o == (own ? mem_addr_i : pc_i), own ? "R2 addr" : "R3 addr",
                  port_addr_o, own ? mem_addr_i : pc_i);
            check(port_we_o == (own && st), own ? "R2 we" : "R3 we", port_we_o, own && st);
            check(pc_hold_o == (own && fr), "R4 pc_hold", pc_hold_o, own && fr);
            check(ifid_hold_o == (own && fr), "R4 ifid_hold", ifid_hold_o, own && fr);
            check(bubble_o == (own && fr), "R4 bubble", bubble_o, own && fr);
            @(posedge clk); #1;
            check(ifid_valid_o == (fr && !own), "R5 ifid_valid", ifid_valid_o, fr && !own);
        end

        // Lone load: third follower slips from cycle 4 to 5
        run_prog(8'b0000_0001, 8'b0000_0000, 7, "R6 lone load fetch cycle");
        // Three back-to-back loads: one stall each
        run_prog(8'b0000_0111, 8'b0000_0000, 8, "R7 load burst fetch cycle");
        // Mixed store and load with a gap
        run_prog(8'b0000_1011, 8'b0000_1001, 8, "R7 store mix fetch cycle");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule